// File: doc/BRIEF.md
# I2C START/STOP Condition Request Controller

This block sits between the software-visible start and stop request flags of a combined master/slave I2C interface and the bus driver that forms the actual line conditions. It turns a held start request into either a START (bus free), a repeated START (already master with at least one byte moved), or a deferred START. A deferred START waits for a STOP on the bus and then for the next half-period tick of the serial clock generator. A stop request produces a STOP command when the interface is master. When the interface is slave, the stop request drives nothing on the bus. Instead the block emulates a received STOP by pulsing a return to the not-addressed slave receiver state.

The bus detectors feed START and STOP pulses, from which the block keeps its own bus-busy state. Every command goes to the bus driver as a one-cycle pulse. The block then ignores new requests until the driver returns a done pulse. The stop flag is held inside the block. Software sets it with a one-cycle write pulse, and the block clears it on its own.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: While `en` is 0, no command or `force_nas` pulse is produced, `sto_set` is ignored, and `sto_flag` and `bus_busy` read 0 one cycle later.
- R2: While `sta_req` is 0, neither `cmd_start` nor `cmd_rstart` is produced.
- R3: From idle, with `sta_req` high and the bus free, `cmd_start` pulses in the cycle after the edge that samples the request, in both master and slave mode.
- R4: With `sta_req` high in slave mode on a busy bus, no START is issued until a bus STOP is seen. `cmd_start` then pulses in the cycle after the first `half_tick` that follows that STOP; `half_tick` before the STOP has no effect.
- R5: In master mode on a busy bus, `sta_req` yields `cmd_rstart` only if a `byte_done` was seen since the last condition; otherwise no command is produced.
- R6: With `sto_flag` set in master mode, `cmd_stop` pulses. `sto_flag` stays 1 through the driver done and clears at the edge that samples the next bus STOP.
- R7: With `sto_flag` set in slave mode, no bus command is produced. `force_nas` pulses for one cycle and `sto_flag` is 0 in that same cycle, and `bus_busy` is left unchanged.
- R8: `bus_busy` is 0 after reset, becomes 1 after a `bus_start` pulse and returns to 0 after a `bus_stop` pulse.
- R9: With both requests present in master mode, the STOP is issued first. Once its bus STOP is seen, `cmd_start` follows two edges later if `sta_req` is still high.
- R10: Commands are one-cycle pulses, at most one at a time. After a command, no further command appears until `drv_done` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Interface enable |
| sta_req | input | 1 | Start request flag (level, owned by software) |
| sto_set | input | 1 | One-cycle write pulse that sets the stop flag |
| is_master | input | 1 | 1 while the interface is in a master mode |
| bus_start | input | 1 | Pulse from the START detector |
| bus_stop | input | 1 | Pulse from the STOP detector |
| byte_done | input | 1 | Pulse at the end of each byte transfer |
| half_tick | input | 1 | Half-period tick of the serial clock generator |
| drv_done | input | 1 | Bus driver finished the last command |
| cmd_start | output | 1 | Generate START |
| cmd_rstart | output | 1 | Generate repeated START |
| cmd_stop | output | 1 | Generate STOP |
| force_nas | output | 1 | Go to not-addressed slave receiver |
| sto_flag | output | 1 | Current stop request flag |
| bus_busy | output | 1 | Bus-busy state |

## Verification
The hardest situation to reach is the deferred START. It needs a busy bus in slave mode, a pending request, `half_tick` pulses that must be ignored, a STOP, and only then a tick. The bench builds this step by step. It marks the bus busy with a detector pulse, holds `sta_req`, and sends ticks before the STOP. It checks for silence at each step and then looks for the single pulse after the first tick that follows the STOP. The combined STOP-then-START case is reached the same way, by keeping `sta_req` high through the whole stop handshake.

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sta_req,
  input  logic sto_set,
  input  logic is_master,
  input  logic bus_start,
  input  logic bus_stop,
  input  logic byte_done,
  input  logic half_tick,
  input  logic drv_done,
  output logic cmd_start,
  output logic cmd_rstart,
  output logic cmd_stop,
  output logic force_nas,
  output logic sto_flag,
  output logic bus_busy
);

  typedef enum logic [2:0] {
    IDLE, WAIT_FREE, WAIT_HALF, CMD_ACK, STOP_ACK, STOP_SEEN
  } st_t;

  st_t  st;
  logic byte_seen;

  wire stay_master = is_master && !bus_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      cmd_start  <= 1'b0;
      cmd_rstart <= 1'b0;
      cmd_stop   <= 1'b0;
      force_nas  <= 1'b0;
      sto_flag   <= 1'b0;
      bus_busy   <= 1'b0;
      byte_seen  <= 1'b0;
    end else begin
      cmd_start  <= 1'b0;
      cmd_rstart <= 1'b0;
      cmd_stop   <= 1'b0;
      force_nas  <= 1'b0;
      if (!en) begin
        st        <= IDLE;
        sto_flag  <= 1'b0;
        bus_busy  <= 1'b0;
        byte_seen <= 1'b0;
      end else begin
        if (bus_start)     bus_busy <= 1'b1;
        else if (bus_stop) bus_busy <= 1'b0;
        if (sto_set) sto_flag <= 1'b1;
        if (!stay_master)   byte_seen <= 1'b0;
        else if (byte_done) byte_seen <= 1'b1;

        case (st)
          IDLE: begin
            if (sto_flag && is_master) begin
              cmd_stop <= 1'b1;
              st       <= STOP_ACK;
            end else if (sto_flag) begin
              force_nas <= 1'b1;
              sto_flag  <= 1'b0;
            end else if (sta_req) begin
              if (!bus_busy) begin
                cmd_start <= 1'b1;
                byte_seen <= 1'b0;
                st        <= CMD_ACK;
              end else if (is_master && byte_seen) begin
                cmd_rstart <= 1'b1;
                byte_seen  <= 1'b0;
                st         <= CMD_ACK;
              end else if (!is_master) begin
                st <= WAIT_FREE;
              end
            end
          end
          WAIT_FREE: begin
            if (!sta_req || sto_flag) st <= IDLE;
            else if (bus_stop)        st <= WAIT_HALF;
          end
          WAIT_HALF: begin
            if (!sta_req || sto_flag) st <= IDLE;
            else if (bus_start)       st <= WAIT_FREE;
            else if (half_tick) begin
              cmd_start <= 1'b1;
              st        <= CMD_ACK;
            end
          end
          CMD_ACK:  if (drv_done) st <= IDLE;
          STOP_ACK: if (drv_done) st <= STOP_SEEN;
          STOP_SEEN: begin
            if (bus_stop) begin
              sto_flag <= 1'b0;
              st       <= IDLE;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_cond_ctrl_chk.sv
module i2c_cond_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic sta_req,
  input logic is_master,
  input logic bus_start,
  input logic cmd_start,
  input logic cmd_rstart,
  input logic cmd_stop,
  input logic force_nas,
  input logic sto_flag,
  input logic bus_busy
);
  wire any_cmd = cmd_start || cmd_rstart || cmd_stop;

  // R1
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(any_cmd || force_nas || sto_flag || bus_busy));

  // R2
  start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start || cmd_rstart) |-> $past(sta_req));

  // R6
  stop_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |-> ($past(sto_flag) && $past(is_master)));

  // R7
  nas_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_nas |-> (!any_cmd && !sto_flag && !$past(is_master)));

  // R8
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bus_start) |=> bus_busy);

  // R10
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_start, cmd_rstart, cmd_stop}));

  // R10
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |=> !any_cmd);
endmodule

bind i2c_cond_ctrl i2c_cond_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sta_req(sta_req), .is_master(is_master),
  .bus_start(bus_start), .cmd_start(cmd_start), .cmd_rstart(cmd_rstart),
  .cmd_stop(cmd_stop), .force_nas(force_nas), .sto_flag(sto_flag),
  .bus_busy(bus_busy)
);

// File: tb/i2c_cond_ctrl_test.sv
module i2c_cond_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 0, rst_n = 0, en = 0, sta_req = 0, sto_set = 0, is_master = 0;
  logic bus_start = 0, bus_stop = 0, byte_done = 0, half_tick = 0, drv_done = 0;
  logic cmd_start, cmd_rstart, cmd_stop, force_nas, sto_flag, bus_busy;
  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cond_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en(en), .sta_req(sta_req), .sto_set(sto_set),
    .is_master(is_master), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_done(byte_done), .half_tick(half_tick), .drv_done(drv_done),
    .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
    .force_nas(force_nas), .sto_flag(sto_flag), .bus_busy(bus_busy)
  );

  // Vector: {master, busy, byte, sto, sta, expected code[2:0]}
  // code: 0 none, 1 start, 2 rstart, 3 stop, 4 not-addressed
  localparam logic [7:0] VEC [9] = '{
    8'b0_0_0_0_1_001,  // R3 slave, free bus
    8'b0_0_0_0_0_000,  // R2 no request
    8'b1_1_1_0_1_010,  // R5 repeated start
    8'b1_1_0_0_1_000,  // R5 no byte yet
    8'b1_1_1_1_0_011,  // R6 master stop
    8'b0_1_0_1_0_100,  // R7 slave stop emulation
    8'b1_1_1_1_1_011,  // R9 stop wins
    8'b0_1_0_0_1_000,  // R4 busy defers
    8'b1_0_0_0_1_001   // R3 master, free bus
  };

  function automatic int code();
    return cmd_start ? 1 : cmd_rstart ? 2 : cmd_stop ? 3 : force_nas ? 4 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(); s = 0;
  endtask

  task automatic do_reset();
    {en, sta_req, sto_set, is_master, bus_start, bus_stop, byte_done, half_tick, drv_done} = '0;
    rst_n = 0; tick(); rst_n = 1; en = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      failures++;
      finished = 1;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R8 reset state
    check("R8 busy after reset", bus_busy, 0);
    check("R6 flag after reset", sto_flag, 0);
    check("R10 no cmd after reset", code(), 0);

    for (int i = 0; i < 9; i++) begin
      do_reset();
      is_master = VEC[i][7];
      if (VEC[i][6]) pulse(bus_start);
      if (VEC[i][5]) pulse(byte_done);
      sto_set = VEC[i][4]; tick(); sto_set = 0;
      sta_req = VEC[i][3]; tick();
      check($sformatf("R3/R5/R6/R7/R9 vector %0d", i), code(), int'(VEC[i][2:0]));
    end

    // R4 deferred start
    do_reset();
    pulse(bus_start);
    check("R8 busy set", bus_busy, 1);
    sta_req = 1; tick();
    check("R4 no start while busy", code(), 0);
    pulse(half_tick);
    check("R4 tick before stop ignored", code(), 0);
    pulse(bus_stop);
    check("R8 busy cleared", bus_busy, 0);
    check("R4 no start at stop", code(), 0);
    tick();
    check("R4 wait for tick", code(), 0);
    pulse(half_tick);
    check("R4 start after half tick", code(), 1);
    tick();
    check("R10 single pulse", code(), 0);
    // R10 no new command until done
    for (int k = 0; k < 4; k++) tick();
    check("R10 held before done", code(), 0);
    sta_req = 0; pulse(drv_done); tick();
    check("R2 idle without request", code(), 0);

    // R6 master stop handshake
    do_reset();
    is_master = 1; pulse(bus_start); pulse(byte_done);
    pulse(sto_set); tick();
    check("R6 stop issued", code(), 3);
    pulse(drv_done);
    check("R6 flag held after done", sto_flag, 1);
    pulse(bus_stop);
    check("R6 flag cleared on bus stop", sto_flag, 0);

    // R7 slave emulation leaves busy
    do_reset();
    pulse(bus_start); pulse(sto_set);
    check("R7 flag set", sto_flag, 1);
    tick();
    check("R7 nas pulse", code(), 4);
    check("R7 flag cleared", sto_flag, 0);
    check("R7 busy untouched", bus_busy, 1);

    // R1 disable
    do_reset();
    en = 0; sta_req = 1; pulse(sto_set); tick();
    check("R1 no command when disabled", code(), 0);
    check("R1 stop write ignored", sto_flag, 0);
    pulse(bus_start);
    check("R1 busy held low", bus_busy, 0);

    // R9 combined requests
    do_reset();
    is_master = 1; pulse(bus_start); pulse(byte_done);
    pulse(sto_set);
    sta_req = 1; tick();
    check("R9 stop first", code(), 3);
    pulse(drv_done);
    check("R9 nothing before bus stop", code(), 0);
    pulse(bus_stop);
    check("R9 no start at stop edge", code(), 0);
    tick();
    check("R9 start follows", code(), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule